// File: doc/BRIEF.md
# Fixed-Priority Core Interrupt Arbiter

This block sits in front of a processor core and reduces sixteen interrupt levels to the one request the core should take next. Level 0 is the reset request and level 1 the non-maskable request. Levels 2 and 3 are held back for future use and never produce a request. Levels 4 to 15 are driven by event sources outside the core. Each usable level has a pending bit that is set by a rising edge on its request line. The bit stays set until the core acknowledges that level by number.

The outcome is registered and shown as a 4-bit level code with a valid flag. The level code is the level number itself. A lower number always wins. An enable mask, loaded through a one-cycle write strobe and always visible on a read-back bus, decides which external levels may win. The reset and non-maskable levels ignore the mask. Turning a level off hides its pending bit but does not clear it.

Top module: `core_irq_arb`

## Requirements
- R1: After synchronous reset, `irq_valid` is 0, `irq_level` is 0 and `mask_rdata` reads 16'h0003, so every external level is disabled.
- R2: A pending bit is set only by a low-to-high change on its request line. `irq_valid` rises two clock edges after the input rises: one edge to latch and one to register. A line held high does not re-arm its level after an acknowledge.
- R3: The reported level is the lowest-numbered level that is both pending and enabled. Level 0 beats level 1, level 1 beats all external levels, and among external levels 4 beats 15. `irq_level` carries the level number in binary.
- R4: Levels 2 and 3 are never reported. Bits 0 to 3 of `mask_rdata` always read 1,1,0,0 (bit 0 first), whatever value is written.
- R5: External level n (4..15) may be reported only while bit n of the mask is 1. A write with `mask_we` high loads bits 15:4 from `mask_wdata` on that clock edge, and the output reflects the new mask one edge later. A pending bit survives while its level is masked.
- R6: Levels 0 and 1 are reported even when every mask bit for levels 4..15 is 0.
- R7: With `ack_valid` high, the pending bit of level `ack_level` clears on that edge. Other levels are untouched, and an acknowledge to an idle or reserved level changes nothing. If a new rising edge of the same level arrives in the same cycle as its acknowledge, the bit stays set.
- R8: A pending bit stays set after its request line falls, until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_req | input | 1 | Reset request, level 0 |
| nmi_req | input | 1 | Non-maskable request, level 1 |
| ext_req | input | 12 | External requests; bit i is level i+4 |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_level | input | 4 | Level being acknowledged |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 16 | Mask write data; bit n enables level n |
| mask_rdata | output | 16 | Current effective enable mask |
| irq_valid | output | 1 | A request is being presented |
| irq_level | output | 4 | Level number of the winning request |

## Verification
The checker assumes that the request lines are clean synchronous levels. It also assumes that an acknowledge names a level the core has been shown, or at worst an idle level. Its property on acknowledge clearing applies only when the request line of that level is low in the acknowledge cycle, so that no new rising edge can set the bit again. The stimulus drives every input half a period away from the rising edge. It keeps all request lines low through reset, so that no edge is latched on reset release. Each request is a single-cycle pulse, except in the one case that holds a line high on purpose.

// File: rtl/core_irq_pkg.sv
package core_irq_pkg;
    // Level space
    localparam int LVL_N    = 16;
    localparam int LVL_W    = $clog2(LVL_N);
    localparam int EXT_BASE = 4;
    localparam int EXT_N    = LVL_N - EXT_BASE;

    typedef logic [LVL_N-1:0] lvl_vec_t;
    typedef logic [LVL_W-1:0] lvl_t;

    // Levels 0 and 1 are always enabled; 2 and 3 never; the rest are writable
    localparam lvl_vec_t FIXED_ON = lvl_vec_t'(3);
    localparam lvl_vec_t WRITABLE = ~lvl_vec_t'((1 << EXT_BASE) - 1);

    typedef struct packed {
        logic valid;
        lvl_t level;
    } grant_t;

    typedef struct packed {
        logic valid;
        lvl_t level;
    } ack_t;

    // Lowest set index wins
    function automatic grant_t pick_first(lvl_vec_t v);
        grant_t g;
        g = '0;
        for (int i = LVL_N - 1; i >= 0; i--) begin
            if (v[i]) begin
                g.valid = 1'b1;
                g.level = lvl_t'(i);
            end
        end
        return g;
    endfunction
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
    import core_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  lvl_vec_t req,
    input  ack_t     ack,
    output lvl_vec_t pend
);
    for (genvar i = 0; i < LVL_N; i++) begin : g_lvl
        logic seen_q;
        logic pend_q;
        logic rise;
        logic hit;

        assign rise = req[i] & ~seen_q;
        assign hit  = ack.valid && (ack.level == lvl_t'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                seen_q <= 1'b0;
                pend_q <= 1'b0;
            end else begin
                seen_q <= req[i];
                // a fresh edge outranks a simultaneous acknowledge
                pend_q <= rise | (pend_q & ~hit);
            end
        end

        assign pend[i] = pend_q;
    end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
    import core_irq_pkg::*;
#(
    parameter lvl_vec_t RESET_EN = '0
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     we,
    input  lvl_vec_t wdata,
    output lvl_vec_t en
);
    lvl_vec_t en_q;

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= (RESET_EN & WRITABLE) | FIXED_ON;
        else if (we)
            en_q <= (wdata & WRITABLE) | FIXED_ON;
    end

    assign en = en_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import core_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  lvl_vec_t pend,
    input  lvl_vec_t en,
    output grant_t   grant
);
    grant_t grant_q;

    always_ff @(posedge clk) begin
        if (rst)
            grant_q <= '0;
        else
            grant_q <= pick_first(pend & en);
    end

    assign grant = grant_q;
endmodule

// File: rtl/core_irq_arb.sv
module core_irq_arb
    import core_irq_pkg::*;
#(
    parameter lvl_vec_t RESET_EN = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rst_req,
    input  logic             nmi_req,
    input  logic [EXT_N-1:0] ext_req,
    input  logic             ack_valid,
    input  logic [LVL_W-1:0] ack_level,
    input  logic             mask_we,
    input  logic [LVL_N-1:0] mask_wdata,
    output logic [LVL_N-1:0] mask_rdata,
    output logic             irq_valid,
    output logic [LVL_W-1:0] irq_level
);
    lvl_vec_t req;
    lvl_vec_t pend;
    lvl_vec_t en;
    ack_t     ack_in;
    grant_t   grant;

    // reserved slots are tied low so they can never latch
    assign req    = {ext_req, {(EXT_BASE - 2){1'b0}}, nmi_req, rst_req};
    assign ack_in = {ack_valid, ack_level};

    irq_pend_bank u_pend (
        .clk  (clk),
        .rst  (rst),
        .req  (req),
        .ack  (ack_in),
        .pend (pend)
    );

    irq_mask_reg #(.RESET_EN(RESET_EN)) u_mask (
        .clk   (clk),
        .rst   (rst),
        .we    (mask_we),
        .wdata (mask_wdata),
        .en    (en)
    );

    irq_arbiter u_arb (
        .clk   (clk),
        .rst   (rst),
        .pend  (pend),
        .en    (en),
        .grant (grant)
    );

    assign mask_rdata = en;
    assign irq_valid  = grant.valid;
    assign irq_level  = grant.level;
endmodule

// File: rtl/core_irq_chk.sv
module core_irq_chk (
    input logic        clk,
    input logic        rst,
    input logic [11:0] ext_req,
    input logic        ack_valid,
    input logic [3:0]  ack_level,
    input logic [15:0] mask_rdata,
    input logic        irq_valid,
    input logic [3:0]  irq_level,
    input logic [15:0] pend
);
    logic [15:0] prev_pend;
    logic [15:0] prev_en;
    logic [15:0] below;
    logic        ack_no_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_pend <= '0;
            prev_en   <= '0;
        end else begin
            prev_pend <= pend;
            prev_en   <= mask_rdata;
        end
    end

    assign below       = (16'd1 << irq_level) - 16'd1;
    assign ack_no_rise = ack_valid && (ack_level >= 4'd4) && !ext_req[ack_level - 4'd4];

    p_reserved_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> (irq_level != 4'd2 && irq_level != 4'd3));

    p_fixed_bits_r4: assert property (@(posedge clk) disable iff (rst)
        mask_rdata[3:0] == 4'b0011);

    p_winner_pending_r3: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> prev_pend[irq_level]);

    p_none_higher_r3: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> ((prev_pend & prev_en & below) == 16'd0));

    p_masked_silent_r5: assert property (@(posedge clk) disable iff (rst)
        (irq_valid && irq_level >= 4'd4) |-> prev_en[irq_level]);

    p_busy_reports_r2: assert property (@(posedge clk) disable iff (rst)
        (|(prev_pend & prev_en)) |-> irq_valid);

    p_nmi_unmasked_r6: assert property (@(posedge clk) disable iff (rst)
        (prev_pend[1] && !prev_pend[0]) |-> (irq_valid && irq_level == 4'd1));

    p_ack_clears_r7: assert property (@(posedge clk) disable iff (rst)
        ack_no_rise |=> !pend[$past(ack_level)]);
endmodule

bind core_irq_arb core_irq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ext_req    (ext_req),
    .ack_valid  (ack_valid),
    .ack_level  (ack_level),
    .mask_rdata (mask_rdata),
    .irq_valid  (irq_valid),
    .irq_level  (irq_level),
    .pend       (pend)
);

// File: tb/sim_core_irq_arb.sv
`timescale 1ns/1ps
module sim_core_irq_arb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rst_req = 1'b0;
    logic        nmi_req = 1'b0;
    logic [11:0] ext_req = '0;
    logic        ack_valid = 1'b0;
    logic [3:0]  ack_level = '0;
    logic        mask_we = 1'b0;
    logic [15:0] mask_wdata = '0;
    logic [15:0] mask_rdata;
    logic        irq_valid;
    logic [3:0]  irq_level;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int          at;
        bit          is_mask;
        logic [15:0] val;
        string       tag;
    } exp_t;
    exp_t sb[$];

    core_irq_arb u0 (
        .clk(clk), .rst(rst), .rst_req(rst_req), .nmi_req(nmi_req),
        .ext_req(ext_req), .ack_valid(ack_valid), .ack_level(ack_level),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .mask_rdata(mask_rdata),
        .irq_valid(irq_valid), .irq_level(irq_level)
    );

    always #4 clk = ~clk;

    // monitor: pop and compare once the scheduled edge has passed
    always @(posedge clk) begin
        cyc = cyc + 1;
        #1;
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            exp_t e;
            logic [15:0] got;
            e = sb.pop_front();
            got = e.is_mask ? mask_rdata : {11'd0, irq_valid, irq_level};
            checks++;
            if (got !== e.val) begin
                errors++;
                $display("FAIL %s: got %h expected %h (cycle %0d)", e.tag, got, e.val, cyc);
            end
        end
    end

    task automatic want_irq(int d, bit v, int lvl, string tag);
        exp_t e;
        e.at = cyc + d; e.is_mask = 1'b0; e.val = {11'd0, v, 4'(lvl)}; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic want_mask(int d, logic [15:0] m, string tag);
        exp_t e;
        e.at = cyc + d; e.is_mask = 1'b1; e.val = m; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_mask(logic [15:0] m, logic [15:0] exp, string tag);
        mask_we = 1'b1; mask_wdata = m;
        want_mask(1, exp, tag);
        step(1);
        mask_we = 1'b0;
        step(2);
    endtask

    task automatic do_ack(int lvl, bit v, int exp_lvl, string tag);
        ack_valid = 1'b1; ack_level = 4'(lvl);
        want_irq(2, v, exp_lvl, tag);
        step(1);
        ack_valid = 1'b0;
        step(2);
    endtask

    task automatic pulse_ext(int lvl, bit v, int exp_lvl, string tag);
        ext_req[lvl-4] = 1'b1;
        want_irq(2, v, exp_lvl, tag);
        step(1);
        ext_req[lvl-4] = 1'b0;
        step(2);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        step(5);
        rst = 1'b0;
        want_irq(1, 0, 0, "R1 idle after reset");
        want_mask(1, 16'h0003, "R1 mask after reset");
        step(3);

        // R4/R5: open all external levels; bits 2,3 stay 0
        write_mask(16'hFFFF, 16'hFFF3, "R4 fixed low bits");

        // R2 timing: not after one edge, valid after two
        ext_req[5] = 1'b1;
        want_irq(1, 0, 0, "R2 not yet after one edge");
        want_irq(2, 1, 9, "R2 level 9 after two edges");
        step(1);
        ext_req[5] = 1'b0;
        step(2);
        want_irq(1, 1, 9, "R8 held after line falls");
        step(2);

        pulse_ext(6, 1, 6, "R3 level 6 beats 9");
        do_ack(6, 1, 9, "R7 ack 6 returns to 9");
        do_ack(12, 1, 9, "R7 ack to idle level no effect");
        do_ack(9, 0, 0, "R7 ack 9 clears");

        // R5: masked level latches but stays hidden
        write_mask(16'hFBFF, 16'hFBF3, "R5 mask readback");
        pulse_ext(10, 0, 0, "R5 masked level hidden");
        mask_we = 1'b1; mask_wdata = 16'hFFFF;
        want_mask(1, 16'hFFF3, "R5 reenable readback");
        want_irq(2, 1, 10, "R5 pending survives mask");
        step(1);
        mask_we = 1'b0;
        step(2);
        do_ack(10, 0, 0, "R7 ack 10 clears");

        // R2: held line does not re-arm
        ext_req[7] = 1'b1;
        want_irq(2, 1, 11, "R2 held line latches");
        step(3);
        do_ack(11, 0, 0, "R2 held line no retrigger");
        want_irq(1, 0, 0, "R2 still quiet while held");
        step(2);
        ext_req[7] = 1'b0;
        step(2);

        // R6: top levels ignore the mask
        write_mask(16'h0000, 16'h0003, "R4 low bits read 0011");
        pulse_ext(5, 0, 0, "R5 all external masked");
        nmi_req = 1'b1;
        want_irq(2, 1, 1, "R6 NMI with mask clear");
        step(1);
        nmi_req = 1'b0;
        step(2);
        rst_req = 1'b1;
        want_irq(2, 1, 0, "R3 reset beats NMI");
        step(1);
        rst_req = 1'b0;
        step(2);
        do_ack(0, 1, 1, "R7 ack 0 leaves NMI");
        do_ack(2, 1, 1, "R7 reserved ack no effect");
        do_ack(1, 0, 0, "R7 ack 1 clears");

        // R7: ack and new edge of level 7 in the same cycle
        write_mask(16'hFFFF, 16'hFFF3, "R5 reopen");
        do_ack(5, 0, 0, "R7 drop stale level 5");
        pulse_ext(7, 1, 7, "R7 level 7 pending");
        ack_valid = 1'b1; ack_level = 4'd7; ext_req[3] = 1'b1;
        want_irq(2, 1, 7, "R7 edge beats same-cycle ack");
        step(1);
        ack_valid = 1'b0; ext_req[3] = 1'b0;
        step(2);
        do_ack(7, 0, 0, "R7 ack 7 clears");

        // R3: extremes of the external range
        ext_req[0] = 1'b1; ext_req[11] = 1'b1;
        want_irq(2, 1, 4, "R3 level 4 beats 15");
        step(1);
        ext_req[0] = 1'b0; ext_req[11] = 1'b0;
        step(2);
        do_ack(4, 1, 15, "R3 level 15 after 4");
        do_ack(15, 0, 0, "R7 ack 15 clears");

        step(4);
        if (sb.size() != 0) begin
            errors++; checks++;
            $display("FAIL scoreboard: got %0d pending expected 0", sb.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end
endmodule